// File: doc/BRIEF.md
# Block DMA Channel Controller

A single DMA channel that moves 16-bit half-words between an on-chip staging FIFO and memory. Work is counted in blocks of 32 half-words (64 bytes). Software programs a start address, which is forced to a 64-byte boundary, and a count of blocks. It then enables the channel through a combined control/status register. The channel issues one memory beat per half-word on a request/acknowledge port and advances its working address by two bytes per beat. At the end of each block it decrements the remaining block count.

When the count runs out, the channel either stops or, in auto-reload mode, restarts from the programmed start address with the programmed count. A terminal-count event can raise an interrupt. Before the channel continues into a block that would begin in a new 512 KiB address region, it halts instead. It then holds an error flag until software clears it.

The FIFO's device side is a 16-bit data register on the CPU port. In the to-memory direction, the CPU pushes half-words into it and the channel drains them. In the from-memory direction, the channel fills it and the CPU pops them. The fill level and the full/empty flags are read back from the same control/status register.

Top module: `blkdma_channel`

## Requirements
- R1: After reset, mem_req and irq are 0, the current address and block count read 0, and the control/status register (offset 0x300) reads 0x0000_0400, which means only the empty flag at bit 10 is set.
- R2: Writing offset 0x000 stores the start address with bits 5:0 forced to zero and copies it into the current address (offset 0x500, read-only). Writing offset 0x402 sets the 16-bit block count (low half of a read at 0x402) and the reload value, which reads back in the low 16 bits of the diagnostic register at 0x100.
- R3: The direction bit is bit 27 of the control register (1 = FIFO to memory). When it is 1, a CPU write to 0x202 pushes bits 15:0 into the FIFO. When it is 0, a CPU read strobe at 0x202 returns the oldest half-word in bits 15:0 and removes it. A write in the wrong direction, or a push into a full FIFO, is dropped. Status bits 7:0 give the fill level, bit 11 is full and bit 10 is empty.
- R4: In the to-memory direction, while the channel runs and the FIFO is not empty, mem_req is 1 with mem_we=1, mem_addr equal to the current address and mem_wdata equal to the oldest FIFO half-word. Each cycle with mem_req and mem_ack both high removes that half-word and adds 2 to the current address.
- R5: In the from-memory direction, mem_req is 1 with mem_we=0 only while the FIFO is not full, and each acknowledged beat pushes mem_rdata into the FIFO.
- R6: After every 32nd acknowledged beat, the block count decreases by one.
- R7: When the block count reaches zero without auto-reload (bit 29), the enable bit (bit 30) clears and requests stop. The pending flag (bit 8) sets only if the interrupt enable (bit 28) is 1, and irq equals pending AND interrupt enable.
- R8: When the block count reaches zero with auto-reload set, the current address reloads from the start address and the count from the reload value, and the channel stays enabled.
- R9: If a completed block leaves blocks outstanding and the next address is a multiple of 2^19, the channel sets the error flag (bit 9), clears enable and stops. The current address and the remaining count are left showing where it stopped.
- R10: While the error flag is set, no request is made even if enable is written to 1. The flag holds until a control write with bit 26 set.
- R11: A control write with bit 30 set clears the pending flag. A control write with bit 31 set empties the FIFO.
- R12: With a block count of zero, an enabled channel makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 12 | Register byte offset |
| cpu_wr | input | 1 | Register write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe; pops the FIFO when cpu_addr is 0x202 |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational from cpu_addr |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = beat writes memory, 0 = beat reads memory |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 16 | Half-word written to memory |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 16 | Half-word read from memory, valid with mem_ack |
| irq | output | 1 | Terminal-count interrupt |

## Verification
The assertions watch, on every cycle, that a request never appears with the error flag set, with a zero block count, or without FIFO data or room for its direction. They also check address stepping within a block, the block-count decrement, the stop or reload at terminal count, and that the error flag persists until cleared. Only the bench scenarios show the data that reaches memory and the FIFO in order, the 64-byte alignment of the start address, and the exact stop address at a 512 KiB boundary. The same holds for the interrupt gating under both enable settings and the fill-level sweep up to a full FIFO with overflow dropped.

// File: rtl/blkdma_pkg.sv
`timescale 1ns/1ps
package blkdma_pkg;

  // register byte offsets within the channel
  localparam logic [11:0] OFS_START  = 12'h000;
  localparam logic [11:0] OFS_DIAG   = 12'h100;
  localparam logic [11:0] OFS_FIFO   = 12'h202;
  localparam logic [11:0] OFS_CTRL   = 12'h300;
  localparam logic [11:0] OFS_BLOCKS = 12'h402;
  localparam logic [11:0] OFS_CUR    = 12'h500;

  // control-word bit positions
  localparam int unsigned CB_FLUSH   = 31;
  localparam int unsigned CB_RUN     = 30;
  localparam int unsigned CB_RELOAD  = 29;
  localparam int unsigned CB_IRQEN   = 28;
  localparam int unsigned CB_TOMEM   = 27;
  localparam int unsigned CB_CLRERR  = 26;

  // status bit positions
  localparam int unsigned SB_FULL    = 11;
  localparam int unsigned SB_EMPTY   = 10;
  localparam int unsigned SB_ERR     = 9;
  localparam int unsigned SB_PEND    = 8;

  typedef struct packed {
    logic flush;
    logic run;
    logic reload;
    logic irq_en;
    logic to_mem;
    logic clr_err;
  } ctrl_cmd_t;

endpackage

// File: rtl/blkdma_fifo.sv
`timescale 1ns/1ps
module blkdma_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full    = (lvl_q == CW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = store[rd_q];
  assign level   = lvl_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    lvl_d = lvl_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = wrap_inc(wr_q);
      if (do_pop)  rd_d = wrap_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + CW'(1);
        2'b01:   lvl_d = lvl_q - CW'(1);
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      lvl_q <= lvl_d;
    end
  end

  // storage has no reset; the write enable is the accepted push
  always_ff @(posedge clk) begin
    if (do_push) store[wr_q] <= push_data;
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= CW'(DEPTH)); // R3
  AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !flush |=> full); // R3

endmodule

// File: rtl/blkdma_seq.sv
`timescale 1ns/1ps
module blkdma_seq
  import blkdma_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned BCW        = 16,
  parameter int unsigned BEATS      = 32,
  parameter int unsigned BOUND_LOG2 = 19
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_wr,
  input  logic [AW-1:0]              start_val,
  input  logic                       blocks_wr,
  input  logic [BCW-1:0]             blocks_val,
  input  logic                       ctrl_wr,
  input  ctrl_cmd_t                  ctrl_val,
  input  logic                       beat_done,
  output logic [AW-1:0]              start_addr,
  output logic [AW-1:0]              cur_addr,
  output logic [BCW-1:0]             blocks_left,
  output logic [BCW-1:0]             blocks_reload,
  output logic [$clog2(BEATS)-1:0]   beat_idx,
  output logic                       enabled,
  output logic                       reload_mode,
  output logic                       irq_en,
  output logic                       to_mem,
  output logic                       err,
  output logic                       pending,
  output logic                       active
);

  localparam int unsigned BTW = $clog2(BEATS);
  localparam int unsigned AL  = $clog2(BEATS * 2);

  logic [AW-1:0]  sa_q, sa_d, ca_q, ca_d, ca_step;
  logic [BCW-1:0] cnt_q, cnt_d, rld_q, rld_d, cnt_dec;
  logic [BTW-1:0] beat_q, beat_d;
  logic           en_q, en_d, ar_q, ar_d, ie_q, ie_d, dir_q, dir_d;
  logic           err_q, err_d, ip_q, ip_d;
  logic           last_beat;
  logic           unused_seq_bits;

  assign unused_seq_bits = ^{start_val[AL-1:0], ctrl_val.flush};

  assign last_beat = (beat_q == BTW'(BEATS - 1));
  assign ca_step   = ca_q + AW'(2);
  assign cnt_dec   = cnt_q - BCW'(1);

  always_comb begin
    sa_d   = sa_q;
    ca_d   = ca_q;
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    beat_d = beat_q;
    en_d   = en_q;
    ar_d   = ar_q;
    ie_d   = ie_q;
    dir_d  = dir_q;
    err_d  = err_q;
    ip_d   = ip_q;

    // control writes first; channel events below take precedence
    if (ctrl_wr) begin
      en_d  = ctrl_val.run;
      ar_d  = ctrl_val.reload;
      ie_d  = ctrl_val.irq_en;
      dir_d = ctrl_val.to_mem;
      if (ctrl_val.run) begin
        ip_d   = 1'b0;
        beat_d = '0;
      end
      if (ctrl_val.clr_err) err_d = 1'b0;
    end

    if (beat_done) begin
      ca_d = ca_step;
      if (last_beat) begin
        beat_d = '0;
        if (cnt_dec == '0) begin
          if (ie_q) ip_d = 1'b1;
          if (ar_q) begin
            ca_d  = sa_q;
            cnt_d = rld_q;
          end else begin
            en_d  = 1'b0;
            cnt_d = '0;
          end
        end else begin
          cnt_d = cnt_dec;
          if (ca_step[BOUND_LOG2-1:0] == '0) begin
            err_d = 1'b1;
            en_d  = 1'b0;
          end
        end
      end else begin
        beat_d = beat_q + BTW'(1);
      end
    end

    // software address and count writes override the channel
    if (start_wr) begin
      sa_d = {start_val[AW-1:AL], {AL{1'b0}}};
      ca_d = {start_val[AW-1:AL], {AL{1'b0}}};
    end
    if (blocks_wr) begin
      cnt_d = blocks_val;
      rld_d = blocks_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q   <= '0;
      ca_q   <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      beat_q <= '0;
      en_q   <= 1'b0;
      ar_q   <= 1'b0;
      ie_q   <= 1'b0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      ip_q   <= 1'b0;
    end else begin
      if (start_wr)                          sa_q   <= sa_d;
      if (start_wr | beat_done)              ca_q   <= ca_d;
      if (blocks_wr | beat_done)             cnt_q  <= cnt_d;
      if (blocks_wr)                         rld_q  <= rld_d;
      if (ctrl_wr | beat_done)               beat_q <= beat_d;
      if (ctrl_wr | beat_done)               en_q   <= en_d;
      if (ctrl_wr) begin
        ar_q  <= ar_d;
        ie_q  <= ie_d;
        dir_q <= dir_d;
      end
      if (ctrl_wr | beat_done) begin
        err_q <= err_d;
        ip_q  <= ip_d;
      end
    end
  end

  assign start_addr    = sa_q;
  assign cur_addr      = ca_q;
  assign blocks_left   = cnt_q;
  assign blocks_reload = rld_q;
  assign beat_idx      = beat_q;
  assign enabled       = en_q;
  assign reload_mode   = ar_q;
  assign irq_en        = ie_q;
  assign to_mem        = dir_q;
  assign err           = err_q;
  assign pending       = ip_q;
  assign active        = en_q & ~err_q & (cnt_q != '0);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && !last_beat && !start_wr |=> ca_q == $past(ca_q) + AW'(2)); // R4
  AST_BLOCK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && last_beat && !blocks_wr && cnt_q > BCW'(1) |=> cnt_q == $past(cnt_q) - BCW'(1)); // R6
  AST_TC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && last_beat && cnt_q == BCW'(1) && !ar_q |=> !en_q); // R7
  AST_TC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && last_beat && cnt_q == BCW'(1) && ar_q && !start_wr && !blocks_wr
    |=> ca_q == $past(sa_q) && cnt_q == $past(rld_q)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(ctrl_wr && ctrl_val.clr_err) |=> err_q); // R10

endmodule

// File: rtl/blkdma_channel.sv
`timescale 1ns/1ps
module blkdma_channel
  import blkdma_pkg::*;
#(
  parameter int unsigned AW              = 32,
  parameter int unsigned FIFO_DEPTH      = 64,
  parameter int unsigned BEATS_PER_BLOCK = 32,
  parameter int unsigned BLK_CNT_W       = 16,
  parameter int unsigned BOUNDARY_LOG2   = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          irq
);

  localparam int unsigned HW  = 16;
  localparam int unsigned BTW = $clog2(BEATS_PER_BLOCK);
  localparam int unsigned CW  = $clog2(FIFO_DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // register decode
  logic sel_start, sel_diag, sel_fifo, sel_ctrl, sel_blocks, sel_cur;
  assign sel_start  = (cpu_addr == OFS_START);
  assign sel_diag   = (cpu_addr == OFS_DIAG);
  assign sel_fifo   = (cpu_addr == OFS_FIFO);
  assign sel_ctrl   = (cpu_addr == OFS_CTRL);
  assign sel_blocks = (cpu_addr == OFS_BLOCKS);
  assign sel_cur    = (cpu_addr == OFS_CUR);

  ctrl_cmd_t ctrl_cmd;
  assign ctrl_cmd.flush   = cpu_wdata[CB_FLUSH];
  assign ctrl_cmd.run     = cpu_wdata[CB_RUN];
  assign ctrl_cmd.reload  = cpu_wdata[CB_RELOAD];
  assign ctrl_cmd.irq_en  = cpu_wdata[CB_IRQEN];
  assign ctrl_cmd.to_mem  = cpu_wdata[CB_TOMEM];
  assign ctrl_cmd.clr_err = cpu_wdata[CB_CLRERR];

  logic ctrl_wr;
  assign ctrl_wr = cpu_wr & sel_ctrl;

  // channel state
  logic [AW-1:0]        start_addr, cur_addr;
  logic [BLK_CNT_W-1:0] blocks_left, blocks_reload;
  logic [BTW-1:0]       beat_idx;
  logic                 enabled, reload_mode, irq_en, to_mem, err, pending, active;
  logic                 beat_done;

  // FIFO
  logic [HW-1:0] fifo_head, fifo_in;
  logic [CW-1:0] fifo_level;
  logic          fifo_full, fifo_empty, fifo_push, fifo_pop, fifo_flush;

  assign fifo_flush = ctrl_wr & ctrl_cmd.flush;
  assign fifo_push  = to_mem ? (cpu_wr & sel_fifo) : beat_done;
  assign fifo_in    = to_mem ? cpu_wdata[HW-1:0] : mem_rdata;
  assign fifo_pop   = to_mem ? beat_done : (cpu_rd & sel_fifo);

  blkdma_fifo #(.W(HW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (fifo_flush),
    .push      (fifo_push),
    .push_data (fifo_in),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  blkdma_seq #(
    .AW(AW), .BCW(BLK_CNT_W), .BEATS(BEATS_PER_BLOCK), .BOUND_LOG2(BOUNDARY_LOG2)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_wr      (cpu_wr & sel_start),
    .start_val     (cpu_wdata[AW-1:0]),
    .blocks_wr     (cpu_wr & sel_blocks),
    .blocks_val    (cpu_wdata[BLK_CNT_W-1:0]),
    .ctrl_wr       (ctrl_wr),
    .ctrl_val      (ctrl_cmd),
    .beat_done     (beat_done),
    .start_addr    (start_addr),
    .cur_addr      (cur_addr),
    .blocks_left   (blocks_left),
    .blocks_reload (blocks_reload),
    .beat_idx      (beat_idx),
    .enabled       (enabled),
    .reload_mode   (reload_mode),
    .irq_en        (irq_en),
    .to_mem        (to_mem),
    .err           (err),
    .pending       (pending),
    .active        (active)
  );

  // memory side
  assign mem_req   = active & (to_mem ? ~fifo_empty : ~fifo_full);
  assign mem_we    = to_mem;
  assign mem_addr  = cur_addr;
  assign mem_wdata = fifo_head;
  assign beat_done = mem_req & mem_ack;
  assign irq       = pending & irq_en;

  // read mux
  always_comb begin
    cpu_rdata = '0;
    if (sel_start) begin
      cpu_rdata[AW-1:0] = start_addr;
    end else if (sel_diag) begin
      cpu_rdata[16 +: BTW]        = beat_idx;
      cpu_rdata[BLK_CNT_W-1:0]    = blocks_reload;
    end else if (sel_fifo) begin
      cpu_rdata[HW-1:0] = fifo_head;
    end else if (sel_ctrl) begin
      cpu_rdata[CB_RUN]    = enabled;
      cpu_rdata[CB_RELOAD] = reload_mode;
      cpu_rdata[CB_IRQEN]  = irq_en;
      cpu_rdata[CB_TOMEM]  = to_mem;
      cpu_rdata[SB_FULL]   = fifo_full;
      cpu_rdata[SB_EMPTY]  = fifo_empty;
      cpu_rdata[SB_ERR]    = err;
      cpu_rdata[SB_PEND]   = pending;
      cpu_rdata[7:0]       = 8'(fifo_level);
    end else if (sel_blocks) begin
      cpu_rdata[BLK_CNT_W-1:0] = blocks_left;
    end else if (sel_cur) begin
      cpu_rdata[AW-1:0] = cur_addr;
    end
  end

  AST_NO_REQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_int_n)
    err |-> !mem_req); // R10
  AST_NO_REQ_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    blocks_left == '0 |-> !mem_req); // R12
  AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && mem_we |-> !fifo_empty); // R4
  AST_READ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req && !mem_we |-> !fifo_full); // R5
  AST_PEND_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pending) |-> $past(beat_done)); // R7

endmodule

// File: tb/test_blkdma_channel.sv
`timescale 1ns/1ps
module test_blkdma_channel;

  localparam logic [11:0] A_START = 12'h000, A_DIAG = 12'h100, A_FIFO = 12'h202,
                          A_CTRL  = 12'h300, A_BLK  = 12'h402, A_CUR  = 12'h500;
  localparam logic [31:0] M_FLUSH = 32'h8000_0000, M_RUN = 32'h4000_0000,
                          M_RLD   = 32'h2000_0000, M_IE  = 32'h1000_0000,
                          M_TOMEM = 32'h0800_0000, M_CLRE = 32'h0400_0000,
                          S_FULL  = 32'h0000_0800, S_EMPTY = 32'h0000_0400,
                          S_ERR   = 32'h0000_0200, S_PEND = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  int          checks = 0, fails = 0;
  int          data_idx = 0;
  logic [31:0] exp_addr = '0;
  logic [31:0] v;

  always #4 clk = ~clk;

  blkdma_channel i_blkdma_channel (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] r);
    cpu_addr = a;
    #1 r = cpu_rdata;
    @(negedge clk);
  endtask

  task automatic pop(output logic [31:0] r);
    cpu_addr = A_FIFO; cpu_rd = 1'b1;
    #1 r = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic serve(input int n, input logic we, input logic chk_data, input string tag);
    int done = 0;
    int idle = 0;
    while (done < n && idle < 100) begin
      #1;
      if (mem_req) begin
        chk(tag, mem_addr, exp_addr);
        chk(tag, {31'b0, mem_we}, {31'b0, we});
        if (chk_data) begin
          chk(tag, {16'b0, mem_wdata}, {16'b0, 16'h3C00 + 16'(data_idx)});
          data_idx++;
        end
        mem_ack = 1'b1;
        mem_rdata = pat(mem_addr);
        exp_addr += 32'd2;
        done++;
      end else begin
        mem_ack = 1'b0;
        idle++;
      end
      @(negedge clk);
    end
    mem_ack = 1'b0;
    chk({tag, " beat count"}, done, n);
  endtask

  task automatic settle_req(input string tag, input logic exp);
    #1 chk(tag, {31'b0, mem_req}, {31'b0, exp});
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(A_CTRL, v);  chk("R1 ctrl after reset", v, S_EMPTY);
    peek(A_CUR, v);   chk("R1 cur addr after reset", v, 32'h0);
    peek(A_BLK, v);   chk("R1 blocks after reset", v, 32'h0);
    #1 chk("R1 irq/req after reset", {30'b0, irq, mem_req}, 32'h0);
    @(negedge clk);

    // R2 register access and alignment sweep
    wr(A_START, 32'h1234_5678);
    peek(A_START, v); chk("R2 start aligned", v, 32'h1234_5640);
    peek(A_CUR, v);   chk("R2 cur copied", v, 32'h1234_5640);
    wr(A_BLK, 32'h0000_ABCD);
    peek(A_BLK, v);   chk("R2 blocks readback", v, 32'h0000_ABCD);
    peek(A_DIAG, v);  chk("R2 reload in diag", {16'b0, v[15:0]}, 32'h0000_ABCD);
    for (int k = 0; k < 64; k++) begin
      wr(A_START, 32'h0000_1000 + 32'(k));
      peek(A_START, v); chk("R2 alignment sweep", v, 32'h0000_1000);
    end

    // R3 fill-level sweep in to-memory direction, overflow dropped
    wr(A_CTRL, M_TOMEM);
    wr(A_BLK, 32'd2);
    for (int k = 0; k <= 64; k++) begin
      peek(A_CTRL, v);
      chk("R3 fill level", {24'b0, v[7:0]}, (k <= 64) ? 32'(k) : 32'd64);
      wr(A_FIFO, 32'h0000_3C00 + 32'(k));
    end
    peek(A_CTRL, v); chk("R3 full after overflow push", v, M_TOMEM | S_FULL | 32'd64);

    // R4/R6/R7 two blocks to memory, interrupt enabled
    wr(A_CTRL, M_RUN | M_IE | M_TOMEM);
    exp_addr = 32'h0000_1000;
    data_idx = 0;
    serve(32, 1'b1, 1'b1, "R4 to-memory block 1");
    peek(A_BLK, v); chk("R6 blocks after first block", v, 32'd1);
    peek(A_CUR, v); chk("R4 cur addr after first block", v, 32'h0000_1040);
    serve(32, 1'b1, 1'b1, "R4 to-memory block 2");
    peek(A_CTRL, v); chk("R7 stop with pending", v, M_IE | M_TOMEM | S_EMPTY | S_PEND);
    peek(A_BLK, v);  chk("R7 blocks zero at end", v, 32'd0);
    #1 chk("R7 irq raised, no request", {30'b0, irq, mem_req}, 32'h2);
    @(negedge clk);

    // R3 wrong-direction write dropped; R11 flush keeps pending until run write
    wr(A_CTRL, M_FLUSH);
    wr(A_FIFO, 32'h0000_FFFF);
    peek(A_CTRL, v); chk("R3 push ignored in from-memory direction", v, S_EMPTY | S_PEND);
    #1 chk("R7 irq gated by enable", {31'b0, irq}, 32'h0);
    @(negedge clk);

    // R5/R8 auto-reload from memory, irq disabled
    wr(A_START, 32'h0000_2000);
    wr(A_BLK, 32'd1);
    wr(A_CTRL, M_RUN | M_RLD);
    peek(A_CTRL, v); chk("R11 run write clears pending", v, M_RUN | M_RLD | S_EMPTY);
    exp_addr = 32'h0000_2000;
    serve(32, 1'b0, 1'b0, "R5 from-memory block 1");
    peek(A_CUR, v);  chk("R8 cur reloaded", v, 32'h0000_2000);
    peek(A_BLK, v);  chk("R8 blocks reloaded", v, 32'd1);
    exp_addr = 32'h0000_2000;
    serve(32, 1'b0, 1'b0, "R5 from-memory block 2");
    peek(A_CTRL, v); chk("R8 still running, FIFO full, no pending", v, M_RUN | M_RLD | S_FULL | 32'd64);
    settle_req("R5 no request when full", 1'b0);
    wr(A_CTRL, 32'h0);
    for (int j = 0; j < 64; j++) begin
      pop(v);
      chk("R5 data order from memory", {16'b0, v[15:0]}, {16'b0, pat(32'h2000 + 32'(2 * (j % 32)))});
    end
    peek(A_CTRL, v); chk("R3 empty after draining", v, S_EMPTY);

    // R9/R10 boundary stop and error clear
    wr(A_START, 32'h0007_FF80);
    wr(A_BLK, 32'd3);
    wr(A_CTRL, M_RUN);
    exp_addr = 32'h0007_FF80;
    serve(32, 1'b0, 1'b0, "R9 block below boundary 1");
    serve(32, 1'b0, 1'b0, "R9 block below boundary 2");
    peek(A_CTRL, v); chk("R9 error stop", v, S_ERR | S_FULL | 32'd64);
    peek(A_CUR, v);  chk("R9 stop address", v, 32'h0008_0000);
    peek(A_BLK, v);  chk("R9 blocks left", v, 32'd1);
    settle_req("R9 no request after error", 1'b0);
    wr(A_CTRL, M_RUN);
    peek(A_CTRL, v); chk("R10 error held", v, M_RUN | S_ERR | S_FULL | 32'd64);
    settle_req("R10 enable ignored under error", 1'b0);
    wr(A_CTRL, M_FLUSH | M_RUN | M_CLRE);
    peek(A_CTRL, v); chk("R10/R11 error cleared and flushed", v, M_RUN | S_EMPTY);
    #1 chk("R10 resumes at boundary", mem_addr, 32'h0008_0000);
    chk("R10 request resumes", {31'b0, mem_req}, 32'h1);
    @(negedge clk);
    wr(A_CTRL, 32'h0);

    // R12 zero block count
    wr(A_BLK, 32'd0);
    wr(A_CTRL, M_RUN);
    peek(A_CTRL, v); chk("R12 enabled with zero blocks", v, M_RUN | S_EMPTY);
    settle_req("R12 no request with zero blocks", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule